// File: doc/BRIEF.md
# Differential QPSK Symbol-to-Bit Decoder

This block sits after the carrier-recovery, timing-recovery and matched-filtering stages of a QPSK receiver. Those stages deliver one recovered symbol at a time. Each symbol arrives as an in-phase sample and a quadrature sample, both in offset-binary form, together with a one-cycle symbol strobe. The block slices each symbol into one of four phase quadrants. It then takes the quadrant step from the previous symbol and turns that step into a two-bit pair. The data is carried by the phase change alone, so any fixed phase rotation that carrier recovery leaves in the symbols does not affect the decoded bits.

Each pair goes out on a single serial line, most significant bit first. A bit-valid strobe marks every output bit, so the output runs at twice the symbol rate. Symbol strobes must be at least two clock cycles apart. With strobes exactly two cycles apart, the output stream has no gaps.

Top module: `dqpsk_pair_decoder`

## Requirements
- R1: A sample is positive when its most significant bit is 1 (code 32 and above for 6 bits) and negative otherwise. The quadrant index is 0 for I+Q+, 1 for I-Q+, 2 for I-Q-, and 3 for I+Q-.
- R2: A sample exactly at mid-scale (code 32) is treated as positive on either axis.
- R3: The step is (current quadrant - previous quadrant) mod 4. The pair is 00 for step 0, 10 for step 1 (+90°), 11 for step 2 (180°), and 01 for step 3 (-90°).
- R4: When a strobed symbol has a predecessor, the first bit (pair MSB) appears on bit_out with bit_vld high in the cycle after the strobe edge. The second bit (pair LSB) appears with bit_vld high in the cycle after that.
- R5: The first strobed symbol after reset only loads the previous quadrant and produces no output bits.
- R6: Sample values present while sym_stb is low have no effect on the previous quadrant or on the output.
- R7: bit_out is 0 whenever bit_vld is 0.
- R8: A synchronous reset clears the previous quadrant, the serializer and bit_vld, and drops any second bit still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_stb | input | 1 | One-cycle strobe marking a valid symbol |
| i_smp | input | 6 | In-phase sample, offset binary |
| q_smp | input | 6 | Quadrature sample, offset binary |
| bit_out | output | 1 | Serial decoded data bit |
| bit_vld | output | 1 | High while bit_out carries a decoded bit |

## Verification
The stimulus walks the quadrant sequence in both directions and with half turns, so every step value and its pair are covered. A design that swaps the +90° and -90° codes, or that decodes the absolute phase instead of the phase change, gives wrong pairs there. Samples at codes 31 and 32 probe the sign boundary; a slicer that compared against code 33 would send mid-scale symbols to the wrong quadrant. Samples that change with the strobe low, and a reset that lands between the two bits of a pair, catch a previous-quadrant register that loads without a strobe and a serializer that leaks its pending bit or emits a pair for the first symbol after reset.

// File: rtl/dqpsk_pkg.sv
package dqpsk_pkg;

    typedef logic [1:0] quad_t;
    typedef logic [1:0] pair_t;

    typedef enum logic [1:0] {
        STEP_NONE  = 2'd0,
        STEP_PLUS  = 2'd1,
        STEP_HALF  = 2'd2,
        STEP_MINUS = 2'd3
    } step_e;

    typedef struct packed {
        quad_t prev_quad;
        logic  have_prev;
    } track_st_t;

    typedef struct packed {
        logic bit_out;
        logic bit_vld;
        logic pend;
        logic pend_bit;
    } ser_st_t;

endpackage

// File: rtl/dqpsk_sign_slicer.sv
module dqpsk_sign_slicer #(
    parameter int SAMPLE_W = 6
) (
    input  logic [SAMPLE_W-1:0] smp,
    output logic                is_pos
);
    localparam int SIGN_BIT = SAMPLE_W - 1;

    // Offset binary: mid-scale and above are non-negative.
    always_comb begin
        is_pos = smp[SIGN_BIT];
    end
endmodule

// File: rtl/dqpsk_quadrant.sv
module dqpsk_quadrant
    import dqpsk_pkg::*;
(
    input  logic  i_pos,
    input  logic  q_pos,
    output quad_t quad
);
    // Counter-clockwise numbering starting in the first quadrant.
    always_comb begin
        unique case ({i_pos, q_pos})
            2'b11:   quad = 2'd0;
            2'b01:   quad = 2'd1;
            2'b00:   quad = 2'd2;
            default: quad = 2'd3;
        endcase
    end
endmodule

// File: rtl/dqpsk_step_map.sv
module dqpsk_step_map
    import dqpsk_pkg::*;
(
    input  quad_t cur_quad,
    input  quad_t prev_quad,
    output pair_t pair
);
    step_e step;

    always_comb begin
        step = step_e'(cur_quad - prev_quad);
        unique case (step)
            STEP_NONE:  pair = 2'b00;
            STEP_PLUS:  pair = 2'b10;
            STEP_HALF:  pair = 2'b11;
            STEP_MINUS: pair = 2'b01;
            default:    pair = 2'b00;
        endcase
    end
endmodule

// File: rtl/dqpsk_serializer.sv
module dqpsk_serializer
    import dqpsk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  pair_t pair,
    output logic  bit_out,
    output logic  bit_vld
);
    ser_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.bit_out  = pair[1];
            st_d.bit_vld  = 1'b1;
            st_d.pend     = 1'b1;
            st_d.pend_bit = pair[0];
        end else if (st_q.pend) begin
            st_d.bit_out  = st_q.pend_bit;
            st_d.bit_vld  = 1'b1;
            st_d.pend     = 1'b0;
            st_d.pend_bit = 1'b0;
        end else begin
            st_d.bit_out  = 1'b0;
            st_d.bit_vld  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_out = st_q.bit_out;
    assign bit_vld = st_q.bit_vld;
endmodule

// File: rtl/dqpsk_pair_decoder.sv
module dqpsk_pair_decoder
    import dqpsk_pkg::*;
#(
    parameter int SAMPLE_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sym_stb,
    input  logic [SAMPLE_W-1:0] i_smp,
    input  logic [SAMPLE_W-1:0] q_smp,
    output logic                bit_out,
    output logic                bit_vld
);
    localparam int N_AXES = 2;

    logic [N_AXES-1:0][SAMPLE_W-1:0] axis_smp;
    logic [N_AXES-1:0]               axis_pos;
    quad_t     cur_quad;
    pair_t     pair;
    track_st_t trk_d, trk_q;
    logic      load_pair;
    logic      have_prev;

    assign axis_smp[0] = i_smp;
    assign axis_smp[1] = q_smp;

    for (genvar ax = 0; ax < N_AXES; ax++) begin : g_axis
        dqpsk_sign_slicer #(.SAMPLE_W(SAMPLE_W)) slicer_i (
            .smp    (axis_smp[ax]),
            .is_pos (axis_pos[ax])
        );
    end

    dqpsk_quadrant quad_i (
        .i_pos (axis_pos[0]),
        .q_pos (axis_pos[1]),
        .quad  (cur_quad)
    );

    dqpsk_step_map map_i (
        .cur_quad  (cur_quad),
        .prev_quad (trk_q.prev_quad),
        .pair      (pair)
    );

    always_comb begin
        trk_d     = trk_q;
        load_pair = sym_stb && trk_q.have_prev;
        if (sym_stb) begin
            trk_d.prev_quad = cur_quad;
            trk_d.have_prev = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign have_prev = trk_q.have_prev;

    dqpsk_serializer ser_i (
        .clk     (clk),
        .rst     (rst),
        .load    (load_pair),
        .pair    (pair),
        .bit_out (bit_out),
        .bit_vld (bit_vld)
    );
endmodule

// File: rtl/dqpsk_pair_decoder_chk.sv
module dqpsk_pair_decoder_chk (
    input logic clk,
    input logic rst,
    input logic sym_stb,
    input logic have_prev,
    input logic bit_out,
    input logic bit_vld
);
    // R4: a strobe with a predecessor yields two valid beats
    a_r4_two_beats: assert property (@(posedge clk) disable iff (rst)
        sym_stb && have_prev |=> bit_vld ##1 bit_vld);

    // R5: first symbol after reset is silent
    a_r5_first_silent: assert property (@(posedge clk) disable iff (rst)
        sym_stb && !have_prev |=> !bit_vld);

    // R7: idle output is zero
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |-> !bit_out);

    // R8: reset clears the valid flag and the history
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> !bit_vld && !have_prev);

    // R6: no strobe, no new history
    a_r6_hold_history: assert property (@(posedge clk) disable iff (rst)
        !sym_stb && !have_prev |=> !have_prev);
endmodule

bind dqpsk_pair_decoder dqpsk_pair_decoder_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .sym_stb   (sym_stb),
    .have_prev (have_prev),
    .bit_out   (bit_out),
    .bit_vld   (bit_vld)
);

// File: tb/dqpsk_pair_decoder_tb_top.sv
module dqpsk_pair_decoder_tb_top;
    localparam int W = 6;
    localparam int NV = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sym_stb = 1'b0;
    logic [W-1:0] i_smp = '0;
    logic [W-1:0] q_smp = '0;
    logic bit_out, bit_vld;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dqpsk_pair_decoder #(.SAMPLE_W(W)) dut_i (
        .clk(clk), .rst(rst), .sym_stb(sym_stb),
        .i_smp(i_smp), .q_smp(q_smp),
        .bit_out(bit_out), .bit_vld(bit_vld)
    );

    // {i, q, expect_output, expected pair}
    localparam logic [14:0] VEC [NV] = '{
        {6'd40, 6'd40, 1'b0, 2'b00},  // R5 first symbol, quadrant 0
        {6'd40, 6'd40, 1'b1, 2'b00},  // R3 step 0
        {6'd10, 6'd40, 1'b1, 2'b10},  // R1 quadrant 1, +90
        {6'd10, 6'd10, 1'b1, 2'b10},  // quadrant 2
        {6'd40, 6'd10, 1'b1, 2'b10},  // quadrant 3
        {6'd40, 6'd40, 1'b1, 2'b10},  // wrap 3 -> 0
        {6'd40, 6'd10, 1'b1, 2'b01},  // -90
        {6'd10, 6'd40, 1'b1, 2'b11},  // 180
        {6'd32, 6'd32, 1'b1, 2'b01},  // R2 mid-scale positive
        {6'd31, 6'd32, 1'b1, 2'b10},  // R2 code 31 negative
        {6'd31, 6'd31, 1'b1, 2'b10},
        {6'd63, 6'd0,  1'b1, 2'b10},
        {6'd0,  6'd63, 1'b1, 2'b11},
        {6'd63, 6'd63, 1'b1, 2'b01},
        {6'd63, 6'd63, 1'b1, 2'b00},
        {6'd0,  6'd0,  1'b1, 2'b11}
    };

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Called at a negedge; returns at a negedge two cycles later.
    task automatic send(input logic [W-1:0] iv, input logic [W-1:0] qv,
                        input logic ev, input logic [1:0] ep, input string req);
        sym_stb = 1'b1; i_smp = iv; q_smp = qv;
        @(negedge clk);
        sym_stb = 1'b0;
        check(req, bit_vld, ev, "first beat valid");
        check(req, bit_out, ev ? ep[1] : 1'b0, "first beat bit (MSB)");
        @(negedge clk);
        check(req, bit_vld, ev, "second beat valid");
        check(req, bit_out, ev ? ep[0] : 1'b0, "second beat bit (LSB)");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8", bit_vld, 1'b0, "reset valid");
        check("R7", bit_out, 1'b0, "reset bit");
        rst = 1'b0;
        @(negedge clk);

        // R1 R2 R3 R4 R5: vector walk, back to back
        for (int k = 0; k < NV; k++) begin
            send(VEC[k][14:9], VEC[k][8:3], VEC[k][2], VEC[k][1:0], "R3/R4");
        end

        // R7: idle after stream
        @(negedge clk);
        check("R7", bit_vld, 1'b0, "idle valid");
        check("R7", bit_out, 1'b0, "idle bit");

        // R6: samples move without strobe; previous quadrant stays 2
        i_smp = 6'd63; q_smp = 6'd63;
        @(negedge clk);
        check("R6", bit_vld, 1'b0, "no strobe valid");
        i_smp = 6'd40; q_smp = 6'd10;
        @(negedge clk);
        check("R6", bit_out, 1'b0, "no strobe bit");
        send(6'd10, 6'd10, 1'b1, 2'b00, "R6");   // 2 -> 2 gives 00

        // R8: reset between the two beats drops the pending LSB
        sym_stb = 1'b1; i_smp = 6'd63; q_smp = 6'd63;   // 2 -> 0 gives 11
        @(negedge clk);
        sym_stb = 1'b0;
        check("R8", bit_vld, 1'b1, "pre-reset first beat valid");
        rst = 1'b1;
        @(negedge clk);
        check("R8", bit_vld, 1'b0, "pending beat dropped");
        check("R8", bit_out, 1'b0, "pending bit dropped");
        rst = 1'b0;
        // R5: history cleared, next symbol silent, then decoding resumes
        send(6'd10, 6'd40, 1'b0, 2'b00, "R5");
        send(6'd10, 6'd10, 1'b1, 2'b10, "R5");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule